// File: doc/BRIEF.md
# Tuner PLL Word Calculator

This block turns a tuning request into the four 21-bit control words and the 10-bit filter-tune value that a synthesizer tuner needs. A request carries an L-band frequency in kHz, a symbol rate in symbols per second and an optional band override. The block accepts it on a valid/ready handshake and works out the result over a few dozen cycles.

The frequency selects one of nine bands. The band gives a band-select word and a VCO divider. The symbol rate selects one of three gain/filter settings. A sequential divider turns the scaled frequency into the N and A counter values. The charge-pump current comes from where the frequency lies inside the chosen band. All results are registered, and a single-cycle done pulse marks them as valid. They are held until the next request completes.

Top module: `tuner_word_calc`

## Requirements
- R1: After reset `req_ready`=1, `done`=0 and every word output is 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 until `done` has pulsed high for exactly one cycle.
- R2: Bands 1..9 start at 950000, 1075000, 1178000, 1296000, 1432000, 1576000, 1718000, 1856000 and 2036000 kHz. Each band ends one below the next band's start, and band 9 ends at 2150000. The band word is 0x40 for band 1 and 0x80 for band 2. For band b in 3..9 it is 0x200 | (1 << (b-3)).
- R3: A frequency outside every band selects band 1.
- R4: A `force_band` value of 1..9 selects that band whatever the frequency is. Any other value means automatic selection.
- R5: The VCO divider is 4 for bands 1 and 2 and 2 for the others. q = floor(freq × div × 10 / 20222). N = floor(q/32) mod 512 and A = q mod 32.
- R6: When A is 0, N is incremented by one, modulo 512.
- R7: The pump current is 1 when the frequency is below floor((low+high)/2) of the chosen band, including a forced band, and 2 otherwise.
- R8: The PLL word is laid out as: [20:19]=3, [18:17]=3, [16]=1, [15:14]=pump, [13:5]=N, [4:0]=A.
- R9: The symbol-rate ranges are [1000000, 4999999], [5000000, 14999999] and [15000000, 45000000]. Their filter-tune values are 0x27F, 0x317 and 0x145. Their VCA words are 0x100E07, 0x100E1F and 0x100E3F. Their VGA words are 0x0B01E0, 0x0B01E0 and 0x0A0180.
- R10: A symbol rate outside all three ranges uses the first range's values.
- R11: Outputs change only on the cycle where `done` is high. Input changes and `req_valid` pulses while `req_ready` is 0 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| freq_khz | input | 22 | Requested frequency in kHz |
| sym_rate | input | 26 | Symbol rate in symbols per second |
| force_band | input | 4 | 1..9 forces a band, other values select it automatically |
| done | output | 1 | One-cycle pulse when the outputs below are updated |
| band_word | output | 21 | Band-select control word |
| pll_word | output | 21 | Packed N/A/pump control word |
| vca_word | output | 21 | VCA control word |
| vga_word | output | 21 | VGA control word |
| filt_tune | output | 10 | Filter-tune value |

## Verification
The assertions assume that `req_valid` is only meaningful while `req_ready` is high. They also assume that the frequency and symbol rate fit the port widths, so that the scaled dividend never overflows 32 bits. The stimulus drives frequencies no larger than 2200000 kHz and rates no larger than 50000000. It raises `req_valid` during a computation only to confirm that the request is ignored. The remainder bound in the divider relies on the divisor being the fixed nonzero reference constant.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int FREQ_W   = 22;
    localparam int SR_W     = 26;
    localparam int WORD_W   = 21;
    localparam int FT_W     = 10;
    localparam int NBANDS   = 9;
    localparam int NAGC     = 3;
    localparam int DIV_W    = 32;
    localparam int BIDX_W   = $clog2(NBANDS);
    localparam int AIDX_W   = $clog2(NAGC);
    localparam logic [DIV_W-1:0] REF_DEN  = 32'd20222;
    localparam logic [31:0]      FREQ_TOP = 32'd2150000;

    typedef struct packed {
        logic [BIDX_W-1:0] idx;
        logic [WORD_W-1:0] code;
        logic [2:0]        vco;
        logic [31:0]       lo;
        logic [31:0]       hi;
    } band_info_t;

    typedef struct packed {
        logic [WORD_W-1:0] vga;
        logic [WORD_W-1:0] vca;
        logic [FT_W-1:0]   ft;
    } agc_set_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } calc_state_t;

    function automatic logic [31:0] band_lo(input int i);
        case (i)
            0: band_lo = 32'd950000;
            1: band_lo = 32'd1075000;
            2: band_lo = 32'd1178000;
            3: band_lo = 32'd1296000;
            4: band_lo = 32'd1432000;
            5: band_lo = 32'd1576000;
            6: band_lo = 32'd1718000;
            7: band_lo = 32'd1856000;
            default: band_lo = 32'd2036000;
        endcase
    endfunction

    function automatic logic [31:0] band_hi(input int i);
        if (i < NBANDS - 1) band_hi = band_lo(i + 1) - 32'd1;
        else                band_hi = FREQ_TOP;
    endfunction

    function automatic logic [WORD_W-1:0] band_code(input int i);
        if (i < 2) band_code = WORD_W'(21'h40 << i);
        else       band_code = WORD_W'(21'h200 | (21'h1 << (i - 2)));
    endfunction

    function automatic logic [2:0] band_vco(input int i);
        band_vco = (i < 2) ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [31:0] sr_lo(input int k);
        case (k)
            0: sr_lo = 32'd1000000;
            1: sr_lo = 32'd5000000;
            default: sr_lo = 32'd15000000;
        endcase
    endfunction

    function automatic logic [31:0] sr_hi(input int k);
        case (k)
            0: sr_hi = 32'd4999999;
            1: sr_hi = 32'd14999999;
            default: sr_hi = 32'd45000000;
        endcase
    endfunction

    function automatic agc_set_t agc_entry(input int k);
        agc_set_t e;
        case (k)
            0: begin e.vga = 21'h0B01E0; e.vca = 21'h100E07; e.ft = 10'h27F; end
            1: begin e.vga = 21'h0B01E0; e.vca = 21'h100E1F; e.ft = 10'h317; end
            default: begin e.vga = 21'h0A0180; e.vca = 21'h100E3F; e.ft = 10'h145; end
        endcase
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] pack_pll(input logic [1:0] pump,
                                                   input logic [8:0] n,
                                                   input logic [4:0] a);
        pack_pll = {2'b11, 2'b11, 1'b1, pump, n, a};
    endfunction

endpackage

// File: rtl/tpc_band_select.sv
module tpc_band_select
    import tpc_pkg::*;
(
    input  logic [FREQ_W-1:0] freq_khz,
    input  logic [3:0]        force_band,
    output band_info_t        band
);
    logic [NBANDS-1:0] hit;

    for (genvar g = 0; g < NBANDS; g++) begin : g_hit
        assign hit[g] = (32'(freq_khz) >= band_lo(g)) && (32'(freq_khz) <= band_hi(g));
    end

    logic [BIDX_W-1:0] sel;
    logic              forced;

    assign forced = (force_band >= 4'd1) && (force_band <= 4'(NBANDS));

    always_comb begin
        sel = '0;
        if (forced) begin
            sel = BIDX_W'(force_band - 4'd1);
        end else begin
            for (int i = 0; i < NBANDS; i++) begin
                if (hit[i]) sel = BIDX_W'(i);
            end
        end
    end

    always_comb begin
        band.idx  = sel;
        band.code = '0;
        band.vco  = '0;
        band.lo   = '0;
        band.hi   = '0;
        for (int i = 0; i < NBANDS; i++) begin
            if (sel == BIDX_W'(i)) begin
                band.code = band_code(i);
                band.vco  = band_vco(i);
                band.lo   = band_lo(i);
                band.hi   = band_hi(i);
            end
        end
    end

endmodule

// File: rtl/tpc_agc_select.sv
module tpc_agc_select
    import tpc_pkg::*;
(
    input  logic [SR_W-1:0] sym_rate,
    output agc_set_t        agc
);
    logic [NAGC-1:0] hit;

    for (genvar g = 0; g < NAGC; g++) begin : g_hit
        assign hit[g] = (32'(sym_rate) >= sr_lo(g)) && (32'(sym_rate) <= sr_hi(g));
    end

    always_comb begin
        agc = agc_entry(0);
        for (int k = 0; k < NAGC; k++) begin
            if (hit[k]) agc = agc_entry(k);
        end
    end

endmodule

// File: rtl/tpc_restoring_div.sv
module tpc_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       trial;
    logic             take;

    assign trial = {rem_q, quo_q[W-1]};
    assign take  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !busy) begin
                rem_q <= '0;
                quo_q <= dividend;
                den_q <= divisor;
                cnt_q <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= take ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem_q < den_q)); // R5
    AST_DIV_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R5

endmodule

// File: rtl/tuner_word_calc.sv
module tuner_word_calc
    import tpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FREQ_W-1:0] freq_khz,
    input  logic [SR_W-1:0]   sym_rate,
    input  logic [3:0]        force_band,
    output logic              done,
    output logic [WORD_W-1:0] band_word,
    output logic [WORD_W-1:0] pll_word,
    output logic [WORD_W-1:0] vca_word,
    output logic [WORD_W-1:0] vga_word,
    output logic [FT_W-1:0]   filt_tune
);
    calc_state_t       state_q;
    logic [FREQ_W-1:0] freq_q;
    logic [SR_W-1:0]   sr_q;
    logic [3:0]        force_q;

    band_info_t        band;
    agc_set_t          agc;

    tpc_band_select u_band (
        .freq_khz   (freq_q),
        .force_band (force_q),
        .band       (band)
    );

    tpc_agc_select u_agc (
        .sym_rate (sr_q),
        .agc      (agc)
    );

    logic [DIV_W-1:0] dividend;
    logic [DIV_W-1:0] quo, rem;
    logic             div_busy, div_fin, div_start;

    assign dividend  = 32'(freq_q) * 32'(band.vco) * 32'd10;
    assign div_start = (state_q == ST_LOAD);

    tpc_restoring_div #(.W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .dividend  (dividend),
        .divisor   (REF_DEN),
        .busy      (div_busy),
        .fin       (div_fin),
        .quotient  (quo),
        .remainder (rem)
    );

    logic [4:0]  a_cnt;
    logic [8:0]  n_cnt;
    logic [31:0] midpoint;
    logic [1:0]  pump;

    assign a_cnt    = quo[4:0];
    assign n_cnt    = quo[13:5] + 9'(a_cnt == 5'd0);
    assign midpoint = (band.lo + band.hi) >> 1;
    assign pump     = (32'(freq_q) < midpoint) ? 2'd1 : 2'd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            freq_q    <= '0;
            sr_q      <= '0;
            force_q   <= '0;
            done      <= 1'b0;
            band_word <= '0;
            pll_word  <= '0;
            vca_word  <= '0;
            vga_word  <= '0;
            filt_tune <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    freq_q  <= freq_khz;
                    sr_q    <= sym_rate;
                    force_q <= force_band;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: state_q <= ST_RUN;
                ST_RUN: if (div_fin) begin
                    band_word <= band.code;
                    pll_word  <= pack_pll(pump, n_cnt, a_cnt);
                    vca_word  <= agc.vca;
                    vga_word  <= agc.vga;
                    filt_tune <= agc.ft;
                    done      <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_BAND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(band_word[8:0]) == 1)); // R2
    AST_PUMP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (pll_word[15:14] == 2'd1 || pll_word[15:14] == 2'd2)); // R7
    AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (rst)
        done |-> (pll_word[20:16] == 5'b11111)); // R8
    AST_FT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (filt_tune == 10'h27F || filt_tune == 10'h317 || filt_tune == 10'h145)); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(pll_word) && $stable(band_word) && $stable(filt_tune))); // R11

endmodule

// File: tb/tuner_word_calc_tb_top.sv
module tuner_word_calc_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [21:0] freq_khz;
    logic [25:0] sym_rate;
    logic [3:0]  force_band;
    logic        done;
    logic [20:0] band_word, pll_word, vca_word, vga_word;
    logic [9:0]  filt_tune;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tuner_word_calc dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .freq_khz   (freq_khz),
        .sym_rate   (sym_rate),
        .force_band (force_band),
        .done       (done),
        .band_word  (band_word),
        .pll_word   (pll_word),
        .vca_word   (vca_word),
        .vga_word   (vga_word),
        .filt_tune  (filt_tune)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic int ref_lo(input int i);
        int t[9] = '{950000, 1075000, 1178000, 1296000, 1432000,
                     1576000, 1718000, 1856000, 2036000};
        return t[i];
    endfunction

    function automatic int ref_hi(input int i);
        return (i == 8) ? 2150000 : ref_lo(i + 1) - 1;
    endfunction

    function automatic int ref_band(input int f, input int fb);
        int idx = 0;
        if (fb >= 1 && fb <= 9) return fb - 1;
        for (int i = 0; i < 9; i++)
            if (f >= ref_lo(i) && f <= ref_hi(i)) idx = i;
        return idx;
    endfunction

    function automatic int ref_bword(input int b);
        return (b < 2) ? (32'h40 << b) : (32'h200 | (1 << (b - 2)));
    endfunction

    function automatic int ref_pll(input int f, input int b);
        longint q;
        int div, n, a, mid, pump;
        div  = (b < 2) ? 4 : 2;
        q    = (longint'(f) * div * 10) / 20222;
        n    = int'((q / 32) % 512);
        a    = int'(q % 32);
        if (a == 0) n = (n + 1) % 512;
        mid  = (ref_lo(b) + ref_hi(b)) / 2;
        pump = (f < mid) ? 1 : 2;
        return (3 << 19) | (3 << 17) | (1 << 16) | (pump << 14) | (n << 5) | a;
    endfunction

    function automatic int ref_agc(input int s);
        if (s >= 5000000 && s <= 14999999) return 1;
        if (s >= 15000000 && s <= 45000000) return 2;
        return 0;
    endfunction

    function automatic int ref_ft(input int k);
        return (k == 0) ? 32'h27F : (k == 1) ? 32'h317 : 32'h145;
    endfunction

    function automatic int ref_vca(input int k);
        return (k == 0) ? 32'h100E07 : (k == 1) ? 32'h100E1F : 32'h100E3F;
    endfunction

    function automatic int ref_vga(input int k);
        return (k == 2) ? 32'h0A0180 : 32'h0B01E0;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input int f, input int s, input int fb);
        @(negedge clk);
        freq_khz   = 22'(f);
        sym_rate   = 26'(s);
        force_band = 4'(fb);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (done !== 1'b1 && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk({req, " done seen"}, int'(done), 1);
    endtask

    task automatic run_and_check(input string req, input int f, input int s, input int fb);
        int b, k;
        issue(f, s, fb);
        wait_done(req);
        b = ref_band(f, fb);
        k = ref_agc(s);
        chk({req, " band_word"}, int'(band_word), ref_bword(b));
        chk({req, " pll_word"},  int'(pll_word),  ref_pll(f, b));
        chk({req, " filt_tune"}, int'(filt_tune), ref_ft(k));
        chk({req, " vca_word"},  int'(vca_word),  ref_vca(k));
        chk({req, " vga_word"},  int'(vga_word),  ref_vga(k));
        @(negedge clk);
        chk({req, " done one cycle (R1)"}, int'(done), 0);
        chk({req, " ready after done (R1)"}, int'(req_ready), 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk("R1 reset ready", int'(req_ready), 1);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset pll", int'(pll_word), 0);
        chk("R1 reset band", int'(band_word), 0);
        chk("R1 reset vca", int'(vca_word), 0);
        chk("R1 reset filt", int'(filt_tune), 0);
    endtask

    task automatic t_bands;
        for (int i = 0; i < 9; i++) begin
            int mid = (ref_lo(i) + ref_hi(i)) / 2;
            run_and_check("R2 R5 R7 R8 band low", ref_lo(i), 27500000, 0);
            run_and_check("R2 R5 R7 R8 band high", ref_hi(i), 27500000, 0);
            run_and_check("R7 below midpoint", mid - 1, 2000000, 0);
            run_and_check("R7 at midpoint", mid, 2000000, 0);
        end
    endtask

    task automatic t_out_of_range;
        run_and_check("R3 below range", 900000, 1000000, 0);
        chk("R3 band 1 word", int'(band_word), 32'h40);
        run_and_check("R3 above range", 2200000, 30000000, 0);
        chk("R3 band 1 word high", int'(band_word), 32'h40);
        run_and_check("R10 low rate", 1200000, 500000, 0);
        chk("R10 filt first", int'(filt_tune), 32'h27F);
        run_and_check("R10 high rate", 1200000, 50000000, 0);
        chk("R10 vca first", int'(vca_word), 32'h100E07);
    endtask

    task automatic t_force;
        run_and_check("R4 force 9", 1000000, 10000000, 9);
        chk("R4 forced band 9 word", int'(band_word), 32'h240);
        run_and_check("R4 force 1", 2100000, 10000000, 1);
        chk("R4 forced band 1 word", int'(band_word), 32'h40);
        run_and_check("R4 force 0 auto", 1500000, 10000000, 0);
        chk("R4 auto band 5", int'(band_word), 32'h204);
        run_and_check("R4 force 10 auto", 1500000, 10000000, 10);
        chk("R4 value 10 auto", int'(band_word), 32'h204);
        run_and_check("R4 force 15 auto", 1000000, 10000000, 15);
    endtask

    task automatic t_a_zero;
        run_and_check("R6 A zero", 1294208, 20000000, 0);
        chk("R6 N bumped literal", int'(pll_word), 32'h1F8520);
    endtask

    task automatic t_agc;
        int rates[6] = '{1000000, 4999999, 5000000, 14999999, 15000000, 45000000};
        foreach (rates[j]) run_and_check("R9 rate range", 1600000, rates[j], 0);
    endtask

    task automatic t_busy;
        int exp_pll;
        issue(1400000, 8000000, 0);
        exp_pll = ref_pll(1400000, ref_band(1400000, 0));
        @(negedge clk);
        freq_khz   = 22'd2000000;
        sym_rate   = 26'd30000000;
        force_band = 4'd2;
        req_valid  = 1'b1;
        @(negedge clk);
        chk("R1 ready low while busy", int'(req_ready), 0);
        chk("R11 outputs held while busy", int'(done), 0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R11 busy ignore");
        chk("R11 busy pll", int'(pll_word), exp_pll);
        chk("R11 busy filt", int'(filt_tune), 32'h317);
        for (int c = 0; c < 5; c++) @(negedge clk);
        chk("R11 hold after done", int'(pll_word), exp_pll);
    endtask

    // ---------------- sequencing ----------------
    initial begin
        rst        = 1'b1;
        req_valid  = 1'b0;
        freq_khz   = '0;
        sym_rate   = '0;
        force_band = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bands();
        t_out_of_range();
        t_force();
        t_a_zero();
        t_agc();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule